// File: doc/BRIEF.md
# 8b/10b Line Encoder with Per-Character Disparity Override

This block turns one byte per transfer into one 10-bit DC-balanced code group. A flag on each transfer chooses between a data character and a control character. A 2-bit command on each transfer can adjust the running disparity before the character is encoded. The encoder keeps the running disparity and drives it on a status pin. A control request that names no legal control character still produces a code group, and it raises an error flag for that character. A bypass flag sends a pre-encoded 10-bit word through unchanged.

Input and output are valid/ready streams with one output register. A transfer is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its code group is on `out_code` from that edge on, with `out_valid` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output and the disparity state hold, and no new transfer is taken. Reset is synchronous and active high.

Top module: `linecode_8b10b_enc`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `rd_pos` is 0 (negative running disparity).
- R2: `in_ready` = !`out_valid` || `out_ready`. The code group of an accepted transfer is on `out_code` with `out_valid` = 1 from the edge that accepts it. While `out_valid` = 1 and `out_ready` = 0, `out_code`, `out_kerr` and `rd_pos` do not change.
- R3: The byte is split as `in_byte[4:0]` = x and `in_byte[7:5]` = y (character D.x.y). With `in_ctrl` = 0 it is encoded with the standard 5b/6b and 3b/4b data tables. The result is `out_code[9:0]` = abcdeifghj, where a is bit 9 and j is bit 0. Examples: D21.5 gives 1010101010; D0.0 gives 1001110100 from negative and 0110001011 from positive disparity.
- R4: For y = 7 the alternate code fghj = 0111 (negative) / 1000 (positive) is used for x in {17,18,20} when the disparity after the 6-bit sub-block is negative, and for x in {11,13,14} when it is positive. Otherwise the primary code 1110/0001 is used.
- R5: With `in_ctrl` = 1, the bytes K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded as control characters. Examples: K28.5 gives 0011111010 from negative and 1100000101 from positive disparity; K23.7 from negative gives 1110101000; K28.7 from negative gives 0011111000.
- R6: With `in_ctrl` = 1 and any other byte, the byte is encoded as the data character and `out_kerr` = 1 for that character. `out_kerr` = 0 for all data and legal control characters.
- R7: The new running disparity is positive if the emitted code has more than five ones, negative if it has fewer, and otherwise equal to the starting disparity.
- R8: Before encoding, `in_dcmd` sets the starting disparity: 00 keeps the current one, 01 inverts it, 10 forces negative, 11 forces positive.
- R9: With command 11 (or 10) on back-to-back K28.5 transfers, the same-polarity comma is emitted twice in a row.
- R10: With `in_bypass` = 1, `out_code` = `in_raw`, `out_kerr` = 0, and the running disparity is unchanged whatever `in_ctrl`, `in_byte` and `in_dcmd` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Encoder can take a transfer |
| in_byte | input | 8 | Character byte, y in [7:5], x in [4:0] |
| in_ctrl | input | 1 | 1 = control character request |
| in_dcmd | input | 2 | Disparity command: keep, invert, force negative, force positive |
| in_bypass | input | 1 | 1 = send in_raw unencoded |
| in_raw | input | 10 | Pre-encoded word for bypass |
| out_valid | output | 1 | Output code group valid |
| out_ready | input | 1 | Downstream takes the code group |
| out_code | output | 10 | Code group, abcdeifghj from bit 9 down to bit 0 |
| out_kerr | output | 1 | Illegal control request for this character |
| rd_pos | output | 1 | Running disparity, 1 = positive |

## Verification
The assertions assume that the source holds `in_valid` and its payload stable until acceptance, and that bypass words are themselves balanced only where the bench claims so. For that reason the code-weight and disparity checks cover only transfers that are not bypassed. The bench drives inputs on falling edges, asserts `in_valid` for exactly one accepting edge, and keeps the presented transfer unchanged across the stall interval. Every non-bypass stimulus is a legal data or control character, or a deliberately illegal control request, and each of these yields a properly weighted code group.

// File: rtl/lc8b10b_pkg.sv
package lc8b10b_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int X_W    = 5;
  localparam int Y_W    = BYTE_W - X_W;
  localparam int SUB6_W = X_W + 1;
  localparam int SUB4_W = Y_W + 1;
  localparam int HALF_W = CODE_W / 2;

  typedef enum logic [1:0] {
    DC_KEEP = 2'b00,
    DC_FLIP = 2'b01,
    DC_NEG  = 2'b10,
    DC_POS  = 2'b11
  } dcmd_e;
endpackage

// File: rtl/lc_disp_sel.sv
module lc_disp_sel
  import lc8b10b_pkg::*;
(
  input  logic  rd_cur,
  input  dcmd_e cmd,
  output logic  rd_start
);
  always_comb begin
    unique case (cmd)
      DC_KEEP: rd_start = rd_cur;
      DC_FLIP: rd_start = ~rd_cur;
      DC_NEG:  rd_start = 1'b0;
      default: rd_start = 1'b1;
    endcase
  end
endmodule

// File: rtl/lc_sub6.sv
module lc_sub6
  import lc8b10b_pkg::*;
(
  input  logic [X_W-1:0]    x,
  input  logic              k28,
  input  logic              rd_in,
  output logic [SUB6_W-1:0] code6,
  output logic              rd_mid
);
  localparam int BAL6 = SUB6_W / 2;
  logic [SUB6_W-1:0] base;
  logic              flip;

  always_comb begin
    unique case (x)
      5'd0:  base = 6'b100111;  5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;  5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;  5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;  5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;  5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;  5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;  5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;  5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;  5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;  5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;  5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;  5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;  5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;  5'd27: base = 6'b110110;
      5'd28: base = 6'b001110;  5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;  default: base = 6'b101011;
    endcase
    if (k28) base = 6'b001111;
    // the balanced D.7 pattern still swaps polarity to avoid long runs
    flip  = rd_in && (($countones(base) != BAL6) || ((x == 5'd7) && !k28));
    code6 = flip ? ~base : base;
    if ($countones(code6) > BAL6)      rd_mid = 1'b1;
    else if ($countones(code6) < BAL6) rd_mid = 1'b0;
    else                               rd_mid = rd_in;
  end
endmodule

// File: rtl/lc_sub4.sv
module lc_sub4
  import lc8b10b_pkg::*;
(
  input  logic [Y_W-1:0]    y,
  input  logic [X_W-1:0]    x,
  input  logic              kmode,
  input  logic              rd_mid,
  output logic [SUB4_W-1:0] code4
);
  localparam int BAL4 = SUB4_W / 2;
  logic [SUB4_W-1:0] kt, dt;
  logic              alt, flip;

  always_comb begin
    unique case (y)
      3'd0: kt = 4'b1011;  3'd1: kt = 4'b0110;
      3'd2: kt = 4'b1010;  3'd3: kt = 4'b1100;
      3'd4: kt = 4'b1101;  3'd5: kt = 4'b0101;
      3'd6: kt = 4'b1001;  default: kt = 4'b0111;
    endcase
    alt = (y == 3'd7) &&
          ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    unique case (y)
      3'd0: dt = 4'b1011;  3'd1: dt = 4'b1001;
      3'd2: dt = 4'b0101;  3'd3: dt = 4'b1100;
      3'd4: dt = 4'b1101;  3'd5: dt = 4'b1010;
      3'd6: dt = 4'b0110;  default: dt = alt ? 4'b0111 : 4'b1110;
    endcase
    flip = rd_mid && (($countones(dt) != BAL4) || (y == 3'd3));
    if (kmode) code4 = rd_mid ? ~kt : kt;
    else       code4 = flip ? ~dt : dt;
  end
endmodule

// File: rtl/linecode_8b10b_enc.sv
module linecode_8b10b_enc
  import lc8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_ctrl,
  input  logic [1:0]        in_dcmd,
  input  logic              in_bypass,
  input  logic [CODE_W-1:0] in_raw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic              out_kerr,
  output logic              rd_pos
);
  logic [X_W-1:0]    x;
  logic [Y_W-1:0]    y;
  logic              k_legal, kmode, rd_start, rd_mid, rd_end;
  logic [SUB6_W-1:0] code6;
  logic [SUB4_W-1:0] code4;
  logic [CODE_W-1:0] enc;
  logic              rd_q;

  assign x = in_byte[X_W-1:0];
  assign y = in_byte[BYTE_W-1:X_W];

  assign k_legal = (x == 5'd28) ||
                   ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  assign kmode   = in_ctrl && k_legal;

  lc_disp_sel u_dsel (.rd_cur(rd_q), .cmd(dcmd_e'(in_dcmd)), .rd_start(rd_start));

  lc_sub6 u_s6 (.x(x), .k28(kmode && (x == 5'd28)), .rd_in(rd_start),
                .code6(code6), .rd_mid(rd_mid));

  lc_sub4 u_s4 (.y(y), .x(x), .kmode(kmode), .rd_mid(rd_mid), .code4(code4));

  assign enc = {code6, code4};

  always_comb begin
    if ($countones(enc) > HALF_W)      rd_end = 1'b1;
    else if ($countones(enc) < HALF_W) rd_end = 1'b0;
    else                               rd_end = rd_start;
  end

  assign in_ready = !out_valid || out_ready;
  assign rd_pos   = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_kerr  <= 1'b0;
      rd_q      <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (in_bypass) begin
          out_code <= in_raw;
          out_kerr <= 1'b0;
        end else begin
          out_code <= enc;
          out_kerr <= in_ctrl && !k_legal;
          rd_q     <= rd_end;
        end
      end
    end
  end
endmodule

// File: rtl/linecode_8b10b_enc_chk.sv
module linecode_8b10b_enc_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_ctrl,
  input logic       in_bypass,
  input logic [9:0] in_raw,
  input logic       out_valid,
  input logic       out_ready,
  input logic [9:0] out_code,
  input logic       out_kerr,
  input logic       rd_pos
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (!out_valid && !rd_pos));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_kerr) && $stable(rd_pos)));

  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  kerr_needs_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (!in_ctrl || in_bypass)) |=> !out_kerr);

  // R7
  code_weight_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_bypass) |=>
      ($countones(out_code) >= 4 && $countones(out_code) <= 6));

  // R7
  rd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_bypass) |=>
      (($countones(out_code) == 5) || (rd_pos == ($countones(out_code) > 5))));

  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(rd_pos));

  // R10
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bypass) |=> ((out_code == $past(in_raw)) && $stable(rd_pos)));
endmodule

bind linecode_8b10b_enc linecode_8b10b_enc_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_ctrl(in_ctrl), .in_bypass(in_bypass), .in_raw(in_raw),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .out_kerr(out_kerr), .rd_pos(rd_pos)
);

// File: tb/sim_linecode_8b10b_enc.sv
module sim_linecode_8b10b_enc;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, in_ctrl, in_bypass, out_valid, out_ready, out_kerr, rd_pos;
  logic [7:0] in_byte;
  logic [1:0] in_dcmd;
  logic [9:0] in_raw, out_code;
  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  linecode_8b10b_enc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_ctrl(in_ctrl), .in_dcmd(in_dcmd),
    .in_bypass(in_bypass), .in_raw(in_raw), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_kerr(out_kerr), .rd_pos(rd_pos)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic k, input logic [1:0] c);
    @(negedge clk);
    in_byte = b; in_ctrl = k; in_dcmd = c; in_bypass = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [9:0] code,
                            input logic kerr, input logic rd);
    check({tag, " code"}, out_code, code);
    check({tag, " kerr"}, {9'd0, out_kerr}, {9'd0, kerr});
    check({tag, " rd"}, {9'd0, rd_pos}, {9'd0, rd});
    check({tag, " valid"}, {9'd0, out_valid}, 10'd1);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_byte = '0; in_ctrl = 1'b0;
    in_dcmd = 2'b00; in_bypass = 1'b0; in_raw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", {9'd0, out_valid}, 10'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {9'd0, out_valid}, 10'd0);
    check("R1 rd after reset", {9'd0, rd_pos}, 10'd0);
  endtask

  task automatic t_comma;
    send(8'hBC, 1'b1, 2'b00); expect_out("R5 R7 K28.5 from neg", 10'b0011111010, 1'b0, 1'b1);
    send(8'hBC, 1'b1, 2'b00); expect_out("R5 R7 K28.5 from pos", 10'b1100000101, 1'b0, 1'b0);
  endtask

  task automatic t_data;
    send(8'hB5, 1'b0, 2'b10); expect_out("R3 D21.5", 10'b1010101010, 1'b0, 1'b0);
    send(8'h00, 1'b0, 2'b10); expect_out("R3 D0.0 neg", 10'b1001110100, 1'b0, 1'b0);
    send(8'h00, 1'b0, 2'b11); expect_out("R3 D0.0 pos", 10'b0110001011, 1'b0, 1'b1);
  endtask

  task automatic t_alt;
    send(8'hF1, 1'b0, 2'b10); expect_out("R4 D17.7 alt neg", 10'b1000110111, 1'b0, 1'b1);
    send(8'hEB, 1'b0, 2'b11); expect_out("R4 D11.7 alt pos", 10'b1101001000, 1'b0, 1'b0);
    send(8'hF1, 1'b0, 2'b11); expect_out("R4 D17.7 primary pos", 10'b1000110001, 1'b0, 1'b0);
  endtask

  task automatic t_override;
    send(8'hB5, 1'b0, 2'b10); expect_out("R8 force neg", 10'b1010101010, 1'b0, 1'b0);
    send(8'h00, 1'b0, 2'b01); expect_out("R8 invert neg", 10'b0110001011, 1'b0, 1'b1);
    send(8'hBC, 1'b1, 2'b01); expect_out("R8 invert pos", 10'b0011111010, 1'b0, 1'b1);
    send(8'hBC, 1'b1, 2'b10); expect_out("R8 force neg from pos", 10'b0011111010, 1'b0, 1'b1);
  endtask

  task automatic t_repeat;
    send(8'hBC, 1'b1, 2'b11); expect_out("R9 K28.5+ first", 10'b1100000101, 1'b0, 1'b0);
    send(8'hBC, 1'b1, 2'b11); expect_out("R9 K28.5+ second", 10'b1100000101, 1'b0, 1'b0);
    send(8'hBC, 1'b1, 2'b10); expect_out("R9 K28.5- first", 10'b0011111010, 1'b0, 1'b1);
    send(8'hBC, 1'b1, 2'b10); expect_out("R9 K28.5- second", 10'b0011111010, 1'b0, 1'b1);
  endtask

  task automatic t_kerr;
    send(8'h00, 1'b1, 2'b10); expect_out("R6 illegal K0.0", 10'b1001110100, 1'b1, 1'b0);
    send(8'hBD, 1'b1, 2'b10); expect_out("R6 illegal K29.5", 10'b1011101010, 1'b1, 1'b1);
    send(8'hB5, 1'b0, 2'b10); expect_out("R6 data clears kerr", 10'b1010101010, 1'b0, 1'b0);
    send(8'hF7, 1'b1, 2'b10); expect_out("R5 K23.7", 10'b1110101000, 1'b0, 1'b0);
    send(8'hFC, 1'b1, 2'b10); expect_out("R5 K28.7", 10'b0011111000, 1'b0, 1'b0);
  endtask

  task automatic t_bypass;
    send(8'hBC, 1'b1, 2'b10); expect_out("R10 setup", 10'b0011111010, 1'b0, 1'b1);
    @(negedge clk);
    in_byte = 8'h00; in_ctrl = 1'b1; in_dcmd = 2'b10; in_bypass = 1'b1;
    in_raw = 10'b1111100000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_bypass = 1'b0;
    expect_out("R10 bypass", 10'b1111100000, 1'b0, 1'b1);
  endtask

  task automatic t_stall;
    @(negedge clk); @(negedge clk);
    check("R2 idle drained", {9'd0, out_valid}, 10'd0);
    out_ready = 1'b0;
    in_byte = 8'hB5; in_ctrl = 1'b0; in_dcmd = 2'b10; in_bypass = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    expect_out("R2 first accepted", 10'b1010101010, 1'b0, 1'b0);
    in_byte = 8'hBC; in_ctrl = 1'b1; in_dcmd = 2'b10;
    #1;
    check("R2 ready low when stalled", {9'd0, in_ready}, 10'd0);
    @(negedge clk);
    expect_out("R2 held one cycle", 10'b1010101010, 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R2 held two cycles", 10'b1010101010, 1'b0, 1'b0);
    out_ready = 1'b1;
    #1;
    check("R2 ready when draining", {9'd0, in_ready}, 10'd1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R2 second after release", 10'b0011111010, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset;
    t_comma;
    t_data;
    t_alt;
    t_override;
    t_repeat;
    t_kerr;
    t_bypass;
    t_stall;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule